// File: doc/BRIEF.md
# PHY-Link Interface Startup Sequencer

This block sits on the PHY side of the link between a physical-layer device and its link-layer controller. After reset or disable, it brings that link back into service. While the link power status input is low, the interface is held dead: the link clock gate is off and the shared control and data lines are released. Once the status input has been low for a minimum restore interval and then rises, the block waits out a wake-up delay. The delay is long if the device was in a low-power state and short otherwise. The block then opens the link clock gate and walks the lines through a fixed, cycle-counted startup pattern. It finishes by parking the lines in the idle state, and from then on link requests are accepted.

The pattern runs in link clock cycles counted from the first enabled cycle:
- In cycle 1 the lines are driven low.
- In cycles 2 to 7 the lines are released, so the link side can drive its own lines low.
- From cycle 8, for a parameterized number of cycles, the receive code is driven on the control lines and all ones on the data lines.
- In the differentiated (isolated) mode, the lines are released again after the first receive cycle.

Any fall of the power status input aborts the sequence or normal operation and returns the block to the dead state. The restore interval then starts over.

Top module: `phylink_init_seq`

## Requirements
- R1: While and right after `rst` is high, the block is dead: `sysclk_en_o`=0, `bus_oe_o`=0, `busy_o`=0, `init_done_o`=0.
- R2: A rise of `lps_i` starts the sequence only if `lps_i` was low for at least RESTORE_CYC consecutive clock edges before it. An earlier rise is ignored and the block stays dead while `lps_i` stays high. The low count must restart from zero.
- R3: After the triggering edge, the block holds `busy_o`=1 with `sysclk_en_o`=0 and `bus_oe_o`=0 for exactly LONG_WAKE cycles if `low_power_i` was 1 at the trigger, or SHORT_WAKE cycles otherwise. After that, `sysclk_en_o` is 1.
- R4: In link clock cycle 1 (the first cycle with `sysclk_en_o`=1), the block drives `ctl_o`=00 (idle) and `d_o`=0 with `bus_oe_o`=1, for that one cycle only.
- R5: In link clock cycles 2 to 7, `bus_oe_o`=0.
- R6: In link clock cycles 8 to 7+RX_CYC, `ctl_o`=10 (receive) and `d_o` is all ones. In direct mode (`diff_mode_i`=0), `bus_oe_o`=1 in all of these cycles.
- R7: In differentiated mode (`diff_mode_i`=1), `bus_oe_o`=1 only in link clock cycle 8 and 0 in the remaining receive cycles.
- R8: After the last receive cycle, the block holds `ctl_o`=00, `d_o`=0, `bus_oe_o`=1, `init_done_o`=1, `busy_o`=0 for as long as `lps_i` stays high.
- R9: `lreq_accept_o` equals `lreq_i` when `init_done_o`=1 and is 0 otherwise.
- R10: If `lps_i` is low at any edge during wake, startup or normal operation, the block is dead on the next cycle (`busy_o`, `init_done_o`, `sysclk_en_o`, `bus_oe_o` all 0). A new start then needs a full restore interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one cycle per link clock cycle |
| rst | input | 1 | Synchronous active-high reset |
| lps_i | input | 1 | Link power status from the link layer |
| low_power_i | input | 1 | 1 when the device is in its low-power state (selects long wake) |
| diff_mode_i | input | 1 | 1 selects differentiated (isolated) mode |
| lreq_i | input | 1 | Link request line |
| sysclk_en_o | output | 1 | Link clock gate enable |
| ctl_o | output | 2 | Control line code: 00 idle, 01 status, 10 receive, 11 transmit |
| d_o | output | D_W | Data line value |
| bus_oe_o | output | 1 | Drive enable for control and data lines (0 = high impedance) |
| busy_o | output | 1 | Startup sequence in progress |
| init_done_o | output | 1 | Interface ready for normal operation |
| lreq_accept_o | output | 1 | Link request accepted |

## Verification
The bench attacks the timing edges of the startup pattern:
- It checks that the wake delay changes with the low-power flag. A design that ignored the flag would release the link clock at the wrong cycle.
- It checks that the receive code appears on exactly the eighth link cycle. An off-by-one counter would show the code in the released window.
- It checks the receive window in both modes. A design that mixed up the modes would keep driving, or release too early, in the second receive cycle.

The bench also raises the power status after too short a low time, and after an abort in wake, startup and ready. A design that did not restart its restore count would come back up when it should stay dead.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE   = 2'b00,
        CTL_STATUS = 2'b01,
        CTL_RECV   = 2'b10,
        CTL_XMIT   = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2,
        PH_READY = 2'd3
    } phase_e;

    // line bundle presented to the pins
    typedef struct packed {
        ctl_e ctl;
        logic ones;
        logic oe;
        logic clk_en;
    } lines_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ifs_restore_timer.sv
module ifs_restore_timer #(
    parameter int unsigned RESTORE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count,
    output logic ripe
);
    localparam int unsigned TW = $clog2(RESTORE_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(RESTORE_CYC);

    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tmr_q <= '0;
        end else if (count && (tmr_q != LIMIT)) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign ripe = (tmr_q == LIMIT);

endmodule

// File: rtl/ifs_step_counter.sv
module ifs_step_counter #(
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [SW-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value <= '0;
        end else begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/ifs_line_drive.sv
module ifs_line_drive
    import ifs_pkg::*;
#(
    parameter int unsigned SW       = 8,
    parameter int unsigned RX_START = 8,
    parameter int unsigned RX_CYC   = 2
) (
    input  phase_e        phase,
    input  logic [SW-1:0] step,
    input  logic          diff_mode,
    output lines_t        lines
);
    // step 0 is link clock cycle 1
    localparam logic [SW-1:0] RX_FIRST = SW'(RX_START - 1);

    always_comb begin
        lines = '{ctl: CTL_IDLE, ones: 1'b0, oe: 1'b0, clk_en: 1'b0};
        unique case (phase)
            PH_OFF, PH_WAKE: ;
            PH_RUN: begin
                lines.clk_en = 1'b1;
                if (step == '0) begin
                    lines.oe = 1'b1;
                end else if (step >= RX_FIRST) begin
                    lines.ctl  = CTL_RECV;
                    lines.ones = 1'b1;
                    lines.oe   = !diff_mode || (step == RX_FIRST);
                end
            end
            PH_READY: begin
                lines.clk_en = 1'b1;
                lines.oe     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phylink_init_seq.sv
module phylink_init_seq
    import ifs_pkg::*;
#(
    parameter int unsigned D_W         = 8,
    parameter int unsigned RESTORE_CYC = 16,
    parameter int unsigned SHORT_WAKE  = 3,
    parameter int unsigned LONG_WAKE   = 360000,
    parameter int unsigned RX_START    = 8,
    parameter int unsigned RX_CYC      = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lps_i,
    input  logic           low_power_i,
    input  logic           diff_mode_i,
    input  logic           lreq_i,
    output logic           sysclk_en_o,
    output logic [1:0]     ctl_o,
    output logic [D_W-1:0] d_o,
    output logic           bus_oe_o,
    output logic           busy_o,
    output logic           init_done_o,
    output logic           lreq_accept_o
);
    localparam int unsigned SPAN = imax(imax(LONG_WAKE, SHORT_WAKE), RX_START + RX_CYC);
    localparam int unsigned SW   = $clog2(SPAN + 1);
    localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_WAKE - 1);
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_WAKE - 1);
    localparam logic [SW-1:0] RUN_LAST   = SW'(RX_START + RX_CYC - 2);

    phase_e        phase_q, phase_d;
    logic          lp_q;
    logic          ripe;
    logic          trigger;
    logic [SW-1:0] step;
    lines_t        lines;

    assign trigger = (phase_q == PH_OFF) && lps_i && ripe;

    ifs_restore_timer #(.RESTORE_CYC(RESTORE_CYC)) u_restore (
        .clk  (clk),
        .rst  (rst),
        .clear((phase_q != PH_OFF) || (lps_i && !ripe)),
        .count((phase_q == PH_OFF) && !lps_i),
        .ripe (ripe)
    );

    ifs_step_counter #(.SW(SW)) u_step (
        .clk  (clk),
        .rst  (rst),
        .clear(phase_d != phase_q),
        .value(step)
    );

    always_comb begin
        phase_d = phase_q;
        if (phase_q != PH_OFF && !lps_i) begin
            phase_d = PH_OFF;
        end else begin
            unique case (phase_q)
                PH_OFF:   if (trigger) phase_d = PH_WAKE;
                PH_WAKE:  if (step == (lp_q ? LONG_LAST : SHORT_LAST)) phase_d = PH_RUN;
                PH_RUN:   if (step == RUN_LAST) phase_d = PH_READY;
                PH_READY: ;
                default:  phase_d = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OFF;
            lp_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (trigger) lp_q <= low_power_i;
        end
    end

    ifs_line_drive #(.SW(SW), .RX_START(RX_START), .RX_CYC(RX_CYC)) u_drive (
        .phase    (phase_q),
        .step     (step),
        .diff_mode(diff_mode_i),
        .lines    (lines)
    );

    assign sysclk_en_o   = lines.clk_en;
    assign ctl_o         = lines.ctl;
    assign d_o           = {D_W{lines.ones}};
    assign bus_oe_o      = lines.oe;
    assign busy_o        = (phase_q == PH_WAKE) || (phase_q == PH_RUN);
    assign init_done_o   = (phase_q == PH_READY);
    assign lreq_accept_o = init_done_o && lreq_i;

    // R1: reset leaves the interface dead
    a_r1_reset_dead: assert property (@(posedge clk)
        rst |=> (!sysclk_en_o && !bus_oe_o && !busy_o && !init_done_o));

    // R4: first enabled link clock cycle drives idle/zero
    a_r4_first_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sysclk_en_o) |-> (bus_oe_o && ctl_o == 2'b00 && d_o == '0));

    // R5: lines released in the cycle after the low drive
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        $rose(sysclk_en_o) |=> !bus_oe_o);

    // R6: receive code always carries all-ones data when driven
    a_r6_rx_ones: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_o && ctl_o == 2'b10) |-> (d_o == '1));

    // R7: differentiated mode releases after the first receive cycle
    a_r7_diff_release: assert property (@(posedge clk) disable iff (rst)
        (diff_mode_i && busy_o && ctl_o == 2'b10 && $past(ctl_o) == 2'b10) |-> !bus_oe_o);

    // R8: ready state holds idle with drive on
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> (bus_oe_o && ctl_o == 2'b00 && d_o == '0 && !busy_o));

    // R9: requests accepted only once ready
    a_r9_req_gate: assert property (@(posedge clk) disable iff (rst)
        lreq_accept_o |-> init_done_o);

    // R10: loss of power status kills the interface
    a_r10_abort: assert property (@(posedge clk) disable iff (rst)
        ((busy_o || init_done_o) && !lps_i) |=> (!busy_o && !init_done_o && !sysclk_en_o && !bus_oe_o));

endmodule

// File: tb/tb_phylink_init_seq.sv
module tb_phylink_init_seq;

    localparam int unsigned D_W = 8;
    localparam int unsigned RC  = 6;
    localparam int unsigned SWK = 3;
    localparam int unsigned LWK = 9;
    localparam int unsigned RXS = 8;
    localparam int unsigned RXC = 2;

    logic clk = 1'b0;
    logic rst, lps, low_power, diff_mode, lreq;
    logic sysclk_en, bus_oe, busy, done, accept;
    logic [1:0] ctl;
    logic [D_W-1:0] d;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    phylink_init_seq #(
        .D_W(D_W), .RESTORE_CYC(RC), .SHORT_WAKE(SWK), .LONG_WAKE(LWK),
        .RX_START(RXS), .RX_CYC(RXC)
    ) dut (
        .clk(clk), .rst(rst), .lps_i(lps), .low_power_i(low_power),
        .diff_mode_i(diff_mode), .lreq_i(lreq), .sysclk_en_o(sysclk_en),
        .ctl_o(ctl), .d_o(d), .bus_oe_o(bus_oe), .busy_o(busy),
        .init_done_o(done), .lreq_accept_o(accept)
    );

    // observed bundle: busy, done, clk_en, oe, accept, ctl[1:0], d
    function automatic logic [14:0] obs();
        return {busy, done, sysclk_en, bus_oe, accept, ctl, d};
    endfunction

    function automatic logic [14:0] pack(input logic b, input logic dn, input logic en,
                                         input logic oe, input logic acc,
                                         input logic [1:0] c, input logic [D_W-1:0] dv);
        return {b, dn, en, oe, acc, c, dv};
    endfunction

    task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (busy,done,en,oe,acc,ctl,d)", req, act, exp);
        end
    endtask

    localparam logic [14:0] DEAD = 15'b0;

    // {low_power, diff_mode, lreq}
    localparam logic [2:0] VEC [6] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b001, 3'b111};

    task automatic full_restore();
        lps = 1'b0;
        repeat (RC + 2) @(negedge clk);
    endtask

    task automatic run_init(input logic lp, input logic df, input logic rq);
        int unsigned wk;
        wk = lp ? LWK : SWK;
        full_restore();
        low_power = lp; diff_mode = df; lreq = rq; lps = 1'b1;
        for (int n = 1; n <= int'(wk + RXS + RXC + 1); n++) begin
            int k;
            @(negedge clk);
            k = n - int'(wk);
            if (k <= 0)
                chk("R3 wake", obs(), pack(1, 0, 0, 0, 0, 2'b00, '0));
            else if (k == 1)
                chk("R4 first cycle", obs(), pack(1, 0, 1, 1, 0, 2'b00, '0));
            else if (k < int'(RXS))
                chk("R5 released", obs(), pack(1, 0, 1, 0, 0, 2'b00, '0));
            else if (k < int'(RXS + RXC))
                chk(df ? "R7 diff receive" : "R6 direct receive", obs(),
                    pack(1, 0, 1, (!df || k == int'(RXS)), 0, 2'b10, '1));
            else
                chk("R8 ready / R9 accept", obs(), pack(0, 1, 1, 1, rq, 2'b00, '0));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; lps = 1'b1; low_power = 1'b0; diff_mode = 1'b0; lreq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset", obs(), DEAD);
        rst = 1'b0;
        @(negedge clk);
        // lps high out of reset without any restore time: stays dead
        chk("R1 after reset", obs(), DEAD);

        // table walk
        for (int i = 0; i < 6; i++) begin
            run_init(VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R9: request toggle while ready
        lreq = 1'b0;
        @(negedge clk);
        chk("R9 no request", obs(), pack(0, 1, 1, 1, 0, 2'b00, '0));

        // R10: abort from ready, then a short low must not restart
        lps = 1'b0;
        @(negedge clk);
        chk("R10 abort ready", obs(), DEAD);
        @(negedge clk);
        lps = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R2 short restore ignored", obs(), DEAD);
        end

        // R2: low for RC-1 edges then high: ignored
        lps = 1'b0;
        repeat (RC - 1) @(negedge clk);
        lps = 1'b1; lreq = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R2 one short", obs(), DEAD);
            chk("R9 dead no accept", {14'b0, accept}, 15'b0);
        end

        // R2 boundary: exactly RC low edges starts
        lps = 1'b0; low_power = 1'b0;
        repeat (RC) @(negedge clk);
        lps = 1'b1;
        @(negedge clk);
        chk("R2 exact restore", obs(), pack(1, 0, 0, 0, 0, 2'b00, '0));

        // R10: abort during wake
        lps = 1'b0;
        @(negedge clk);
        chk("R10 abort wake", obs(), DEAD);

        // R10: abort during released window of startup
        full_restore();
        lps = 1'b1; low_power = 1'b0;
        repeat (SWK + 3) @(negedge clk);
        chk("R5 mid startup", obs(), pack(1, 0, 1, 0, 0, 2'b00, '0));
        lps = 1'b0;
        @(negedge clk);
        chk("R10 abort startup", obs(), DEAD);
        lps = 1'b1;
        @(negedge clk);
        chk("R10 restore restarted", obs(), DEAD);

        // full sequence still works afterwards
        run_init(1'b1, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule